// File: doc/BRIEF.md
# SMRAM Window Decoder and Software SMI Trap

This block sits in the power-management corner of a system controller. It watches configuration register writes and keeps a private copy of the few control bytes it needs. From one window-control byte it decodes a remap window for system-management RAM. The window has a host-visible base, a backing RAM base, an enable and an attribute flag. The window size is fixed at 64 KB, so no size is output.

The block also watches the host I/O write bus for a write to a programmable 16-bit trap port. When the trap is armed and that port is written, the block emits a one-cycle request. The request goes either to the SMI line or to an interrupt line, and in the interrupt case the block also reports the IRQ number. The same trigger sets a sticky status bit and a soft-reset mask flag. Software clears the status bit by writing a one to it and clears the mask flag by writing any value to a dedicated clear register. The CPU's SMM handshake and the interrupt controller lie outside the block.

Top module: `smm_trap`

## Requirements
- R1: After reset the window is enabled with host base 0xE0000, RAM base 0xA0000 and attribute 0. The SMI and IRQ pulses, the status bit, the mask flag and the IRQ number are all 0.
- R2: Bit 7 of the window-control byte (index 0x13) selects the host base: 0x60000 when set, 0xE0000 when clear.
- R3: Bits 6:5 of the window-control byte select the RAM base: 00 gives 0xA0000 and 01 gives 0xB0000. 10 gives 0xE0000 when bit 7 is clear and disabled when bit 7 is set. 11 is always disabled. When disabled, the enable output is 0 and the RAM base output is 0.
- R4: Bit 4 of the window-control byte appears on the attribute output.
- R5: The window outputs change on the clock edge that accepts a write to index 0x13, and only when bits 7:4 change. They hold their values at all other times.
- R6: The trap is armed only when bit 7 of the mode byte (index 0x0B) and bit 1 of the arm byte (index 0x18) are both set. The trap port is {byte at 0x15, byte at 0x14}. An I/O write to any other port, or any write while the trap is unarmed, has no effect.
- R7: A trigger raises the SMI pulse when mode bit 4 is set. Otherwise it raises the IRQ pulse and loads the IRQ number: 15 when mode bit 3 is set, 12 when it is clear.
- R8: Each triggering I/O write produces exactly one pulse, one cycle after the write. Triggers on back-to-back cycles give pulses on back-to-back cycles.
- R9: A trigger sets the status bit. Writing to index 0x19 with data bit 1 set clears it, and writing with data bit 1 clear leaves it unchanged. A trigger in the same cycle wins.
- R10: A trigger sets the soft-reset mask flag. Any write to index 0x1C clears it. A trigger in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_idx | input | 8 | Configuration register index |
| cfg_data | input | 8 | Configuration write data |
| io_wr | input | 1 | Host I/O write strobe |
| io_addr | input | 16 | Host I/O write port address |
| smram_en | output | 1 | SMRAM window enable |
| smram_host | output | 20 | Host-visible window base |
| smram_ram | output | 20 | Backing RAM base (0 when disabled) |
| smram_attr | output | 1 | Window attribute flag |
| smi_pulse | output | 1 | One-cycle SMI request |
| irq_pulse | output | 1 | One-cycle interrupt request |
| irq_num | output | 4 | Interrupt line for the last IRQ trigger |
| rst_mask | output | 1 | Soft-reset mask flag |
| trig_stat | output | 1 | Sticky trigger status bit |

## Verification
On every cycle, the assertions check the following. SMI and IRQ never pulse together. Every pulse follows an I/O write and leaves the status and mask flags set. The enable agrees with a legal RAM base, and the host base is one of its two values. The window outputs stay still unless the window byte was written. The mask flag only drops after a write to its clear register. The bench scenarios are needed to show the rest: that the decoded bases match each control encoding, that the trap fires only for the exact programmed port when armed, and that routing follows the mode bits. They also cover back-to-back triggers and the write-one-to-clear behaviour of the status bit.

// File: rtl/smm_trap.sv
module smm_trap #(
  parameter logic [7:0] IDX_MODE = 8'h0B,
  parameter logic [7:0] IDX_WIN  = 8'h13,
  parameter logic [7:0] IDX_TLO  = 8'h14,
  parameter logic [7:0] IDX_THI  = 8'h15,
  parameter logic [7:0] IDX_ARM  = 8'h18,
  parameter logic [7:0] IDX_STAT = 8'h19,
  parameter logic [7:0] IDX_MCLR = 8'h1C,
  parameter logic [3:0] IRQ_HI   = 4'd15,
  parameter logic [3:0] IRQ_LO   = 4'd12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [7:0]  cfg_idx,
  input  logic [7:0]  cfg_data,
  input  logic        io_wr,
  input  logic [15:0] io_addr,
  output logic        smram_en,
  output logic [19:0] smram_host,
  output logic [19:0] smram_ram,
  output logic        smram_attr,
  output logic        smi_pulse,
  output logic        irq_pulse,
  output logic [3:0]  irq_num,
  output logic        rst_mask,
  output logic        trig_stat
);
  localparam logic [19:0] HOST_LOW  = 20'h60000;
  localparam logic [19:0] HOST_HIGH = 20'hE0000;
  localparam logic [19:0] RAM_A     = 20'hA0000;
  localparam logic [19:0] RAM_B     = 20'hB0000;
  localparam logic [19:0] RAM_E     = 20'hE0000;

  logic [7:0]  mode_q, tlo_q, thi_q;
  logic        arm_q;
  logic [3:0]  win_q;
  logic [19:0] ram_n;

  wire win_wr  = cfg_wr && (cfg_idx == IDX_WIN);
  wire win_chg = win_wr && (cfg_data[7:4] != win_q);
  wire [19:0] host_n = cfg_data[7] ? HOST_LOW : HOST_HIGH;
  wire armed = mode_q[7] && arm_q;
  wire hit   = io_wr && armed && (io_addr == {thi_q, tlo_q});
  wire clr_stat = cfg_wr && (cfg_idx == IDX_STAT) && cfg_data[1];
  wire clr_mask = cfg_wr && (cfg_idx == IDX_MCLR);

  always_comb begin
    case (cfg_data[6:5])
      2'b00:   ram_n = RAM_A;
      2'b01:   ram_n = RAM_B;
      2'b10:   ram_n = cfg_data[7] ? 20'h0 : RAM_E;
      default: ram_n = 20'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      tlo_q  <= '0;
      thi_q  <= '0;
      arm_q  <= 1'b0;
    end else if (cfg_wr) begin
      if (cfg_idx == IDX_MODE) mode_q <= cfg_data;
      if (cfg_idx == IDX_TLO)  tlo_q  <= cfg_data;
      if (cfg_idx == IDX_THI)  thi_q  <= cfg_data;
      if (cfg_idx == IDX_ARM)  arm_q  <= cfg_data[1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q      <= '0;
      smram_en   <= 1'b1;
      smram_host <= HOST_HIGH;
      smram_ram  <= RAM_A;
      smram_attr <= 1'b0;
    end else if (win_chg) begin
      win_q      <= cfg_data[7:4];
      smram_en   <= (ram_n != 20'h0);
      smram_host <= host_n;
      smram_ram  <= ram_n;
      smram_attr <= cfg_data[4];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smi_pulse <= 1'b0;
      irq_pulse <= 1'b0;
      irq_num   <= '0;
      trig_stat <= 1'b0;
      rst_mask  <= 1'b0;
    end else begin
      smi_pulse <= hit && mode_q[4];
      irq_pulse <= hit && !mode_q[4];
      if (hit && !mode_q[4]) irq_num <= mode_q[3] ? IRQ_HI : IRQ_LO;
      if (hit) trig_stat <= 1'b1;
      else if (clr_stat) trig_stat <= 1'b0;
      if (hit) rst_mask <= 1'b1;
      else if (clr_mask) rst_mask <= 1'b0;
    end
  end
endmodule

module smm_trap_chk #(
  parameter logic [7:0] IDX_WIN  = 8'h13,
  parameter logic [7:0] IDX_MCLR = 8'h1C,
  parameter logic [3:0] IRQ_HI   = 4'd15,
  parameter logic [3:0] IRQ_LO   = 4'd12
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr,
  input logic [7:0]  cfg_idx,
  input logic        io_wr,
  input logic        smram_en,
  input logic [19:0] smram_host,
  input logic [19:0] smram_ram,
  input logic        smram_attr,
  input logic        smi_pulse,
  input logic        irq_pulse,
  input logic [3:0]  irq_num,
  input logic        rst_mask,
  input logic        trig_stat
);
  // R7
  route_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(smi_pulse && irq_pulse));
  // R7
  irq_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> (irq_num == IRQ_HI || irq_num == IRQ_LO));
  // R8
  pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smi_pulse || irq_pulse) |-> $past(io_wr));
  // R9
  pulse_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smi_pulse || irq_pulse) |-> (trig_stat && rst_mask));
  // R3
  en_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smram_en == (smram_ram == 20'hA0000 || smram_ram == 20'hB0000 || smram_ram == 20'hE0000));
  // R2
  host_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smram_host == 20'h60000 || smram_host == 20'hE0000);
  // R5
  win_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_wr && cfg_idx == IDX_WIN) |->
      ($stable(smram_en) && $stable(smram_host) && $stable(smram_ram) && $stable(smram_attr)));
  // R10
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_mask) |-> $past(cfg_wr && cfg_idx == IDX_MCLR));
endmodule

bind smm_trap smm_trap_chk #(.IDX_WIN(IDX_WIN), .IDX_MCLR(IDX_MCLR),
  .IRQ_HI(IRQ_HI), .IRQ_LO(IRQ_LO)) u_chk (.*);

// File: tb/smm_trap_bench.sv
module smm_trap_bench;
  localparam int PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_wr = 1'b0, io_wr = 1'b0;
  logic [7:0]  cfg_idx = '0, cfg_data = '0;
  logic [15:0] io_addr = '0;
  logic        smram_en, smram_attr, smi_pulse, irq_pulse, rst_mask, trig_stat;
  logic [19:0] smram_host, smram_ram;
  logic [3:0]  irq_num;

  smm_trap u_smm_trap (.*);

  always #(PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;
  logic done = 1'b0;

  logic [7:0] e_mode = 0, e_tlo = 0, e_thi = 0;
  logic e_arm = 0, e_stat = 0, e_mask = 0, e_smi = 0, e_irq = 0;
  logic [3:0] e_irqn = 0;
  logic [3:0] e_win = 0;

  function automatic logic [19:0] f_host(input logic [3:0] w);
    return w[3] ? 20'h60000 : 20'hE0000;
  endfunction
  function automatic logic [19:0] f_ram(input logic [3:0] w);
    case (w[2:1])
      2'b00: return 20'hA0000;
      2'b01: return 20'hB0000;
      2'b10: return w[3] ? 20'h0 : 20'hE0000;
      default: return 20'h0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check({tag, " R2 host"}, smram_host, f_host(e_win));
    check({tag, " R3 ram"}, smram_ram, f_ram(e_win));
    check({tag, " R3 en"}, smram_en, f_ram(e_win) != 0);
    check({tag, " R4 attr"}, smram_attr, e_win[0]);
    check({tag, " R7 smi"}, smi_pulse, e_smi);
    check({tag, " R7 irq"}, irq_pulse, e_irq);
    check({tag, " R7 irqn"}, irq_num, e_irqn);
    check({tag, " R9 stat"}, trig_stat, e_stat);
    check({tag, " R10 mask"}, rst_mask, e_mask);
  endtask

  function automatic logic model_hit(input logic [15:0] a);
    return e_mode[7] && e_arm && (a == {e_thi, e_tlo});
  endfunction

  task automatic model_io(input logic [15:0] a);
    logic h = model_hit(a);
    e_smi = h && e_mode[4];
    e_irq = h && !e_mode[4];
    if (e_irq) e_irqn = e_mode[3] ? 4'd15 : 4'd12;
    if (h) begin e_stat = 1; e_mask = 1; end
  endtask

  task automatic model_cfg(input logic [7:0] i, input logic [7:0] d);
    case (i)
      8'h0B: e_mode = d;
      8'h13: e_win = d[7:4];
      8'h14: e_tlo = d;
      8'h15: e_thi = d;
      8'h18: e_arm = d[1];
      8'h19: if (d[1]) e_stat = 0;
      8'h1C: e_mask = 0;
      default: ;
    endcase
  endtask

  task automatic cfg(input logic [7:0] i, input logic [7:0] d, input string tag);
    @(negedge clk); cfg_wr = 1; cfg_idx = i; cfg_data = d;
    @(negedge clk); cfg_wr = 0;
    e_smi = 0; e_irq = 0;
    model_cfg(i, d);
    check_all(tag);
  endtask

  task automatic iow(input logic [15:0] a, input string tag);
    @(negedge clk); io_wr = 1; io_addr = a;
    @(negedge clk); io_wr = 0;
    model_io(a);
    check_all(tag);
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check_all("R1 reset");
    // R3 every window encoding, R5 update
    for (int k = 0; k < 16; k++) cfg(8'h13, {k[3:0], 4'hA}, "R5 win sweep");
    cfg(8'h13, 8'hC0, "R3 e-disabled");
    cfg(8'h13, 8'h40, "R3 e-base");
    // R6 unarmed trap
    cfg(8'h14, 8'h34, "R6 lo");
    cfg(8'h15, 8'h12, "R6 hi");
    iow(16'h1234, "R6 unarmed");
    cfg(8'h0B, 8'h80, "R6 mode");
    iow(16'h1234, "R6 half armed");
    cfg(8'h18, 8'h02, "R6 arm");
    iow(16'h1235, "R6 wrong port");
    iow(16'h1234, "R7 irq12");
    cfg(8'h19, 8'h00, "R9 write zero");
    cfg(8'h19, 8'h02, "R9 clear");
    cfg(8'h1C, 8'h00, "R10 clear");
    cfg(8'h0B, 8'h88, "R7 mode");
    iow(16'h1234, "R7 irq15");
    cfg(8'h0B, 8'h90, "R7 smi mode");
    // R8 back-to-back triggers
    @(negedge clk); io_wr = 1; io_addr = 16'h1234;
    @(negedge clk);
    model_io(16'h1234); check_all("R8 first");
    @(negedge clk); io_wr = 0;
    model_io(16'h1234); check_all("R8 second");
    @(negedge clk);
    e_smi = 0; e_irq = 0; check_all("R8 gap");
    // R9/R10 trigger wins over same-cycle clear
    @(negedge clk); io_wr = 1; cfg_wr = 1; cfg_idx = 8'h19; cfg_data = 8'hFF;
    @(negedge clk); io_wr = 0; cfg_wr = 0;
    model_io(16'h1234); check_all("R9 set wins");
    @(negedge clk); io_wr = 1; cfg_wr = 1; cfg_idx = 8'h1C;
    @(negedge clk); io_wr = 0; cfg_wr = 0;
    model_io(16'h1234); check_all("R10 set wins");
    // random mix
    for (int n = 0; n < 600; n++) begin
      int unsigned op = $urandom_range(0, 9);
      logic [7:0] d = 8'($urandom);
      case (op)
        0: cfg(8'h13, d, "R5 rnd win");
        1: cfg(8'h0B, d | 8'h80, "R7 rnd mode");
        2: cfg(8'h18, d, "R6 rnd arm");
        3: cfg(8'h14, 8'($urandom_range(0, 3)), "R6 rnd lo");
        4: cfg(8'h19, d, "R9 rnd clr");
        5: cfg(8'h1C, d, "R10 rnd clr");
        6: cfg(d, 8'($urandom), "R6 rnd idx");
        default: iow({e_thi, 8'($urandom_range(0, 3))}, "R8 rnd io");
      endcase
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule